// File: doc/BRIEF.md
# Embedded Program/Erase Status Word Generator

This block forms the 16-bit word a flash array returns on a read while its internal program or erase engine is working, and for a while after a failure. The controller supplies the current operation kind, bit 7 of the word being written, the mask of blocks chosen for erase, the block index decoded from the read address, and its failure and erase-window flags. The block turns these into a data-polling bit, two toggle bits, a sticky error bit and an erase-started bit.

Each status read is marked by a single-cycle strobe. The word is captured in an output register on that edge. The two toggle flip-flops advance on the same edge, so one read produces exactly one inversion. The first toggle bit follows any running operation. The second one moves only when the read addresses a block that is being erased, or a block whose erase failed. This lets software see both that the engine is busy and which block it is working on. When no operation is running and no error is held, the array data passes straight through.

Top module: `pes_status_word`

## Requirements
- R1: With op_kind = 1 (program), a status read returns bit 7 equal to the inverse of prog_bit7, bit 2 = 1 and bit 3 = 0.
- R2: Bit 6 of the status word alternates on every strobed read while op_kind is 1, 2, 3 or 5, or while an error is held with op_kind = 0. In suspend (op_kind = 4), and on idle pass-through reads, it does not change from read to read.
- R3: With op_kind = 2 (block erase), bit 7 = 0. Bit 2 alternates on reads of blocks whose erase_sel bit is set, and reads 1 on other blocks.
- R4: With op_kind = 3 (chip erase), bit 2 alternates on reads of every block, whatever erase_sel holds.
- R5: With op_kind = 4 (erase suspended), a read of a selected block returns bit 7 = 1, bit 6 = 1, bit 3 = 1 and an alternating bit 2. A read of an unselected block, or of a block index of NUM_BLK or more, returns array_q unchanged.
- R6: With op_kind = 5 (program inside suspend), bit 7 is the inverse of prog_bit7 and bit 6 alternates. Bit 2 alternates on selected blocks and reads 1 elsewhere.
- R7: Bit 5 is set by a fail_evt pulse and stays set until clr_err. If both arrive in the same cycle, the set wins. The bit is visible to reads strobed after the edge that captured the pulse.
- R8: With op_kind = 0 and an error held, reads return a status word with bit 5 = 1 and bit 3 = 1. Bit 7 is the inverse of the write data's bit 7 if the failure occurred during a program (op 1 or 5), and 0 otherwise. Bit 2 alternates only on blocks that were being erased when the failure occurred (all blocks for chip erase).
- R9: During erase (op_kind 2 or 3), bit 3 is 0 while win_open is 1 and 1 once win_open is 0.
- R10: Every status word has bits 15:8, bit 4 and bits 1:0 at zero. With op_kind = 0 and no error held, reads return array_q.
- R11: rd_data, and both toggle bits, reset to 0. rd_data changes only on the edge that samples rd_stb high and is held otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_kind | input | 3 | 0 idle, 1 program, 2 block erase, 3 chip erase, 4 erase suspended, 5 program in suspend |
| prog_bit7 | input | 1 | Bit 7 of the word being programmed |
| erase_sel | input | NUM_BLK | One bit per block chosen for erase |
| rd_blk | input | BLK_W | Block index of the read address |
| rd_stb | input | 1 | Single-cycle read strobe |
| array_q | input | 16 | Array data for pass-through reads |
| fail_evt | input | 1 | Controller reports a program or erase failure |
| clr_err | input | 1 | Read/reset command clears the error |
| win_open | input | 1 | Multi-block erase acceptance window still open |
| rd_data | output | 16 | Registered read word |

## Verification
Every read result is due exactly one clock edge after the edge that samples rd_stb high. The scoreboard therefore marks a strobe at the rising edge and compares the popped expectation at the following falling edge, when rd_data has settled. A failure or clear pulse acts on the edge it is sampled on. The bench always issues it a full cycle before the next strobe and updates its own model at the same point, so that read sees the new error state. Held-value checks change array_q without a strobe and sample after one more edge.

// File: rtl/pes_pkg.sv
package pes_pkg;

  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_PROG      = 3'd1,
    OP_BERASE    = 3'd2,
    OP_CERASE    = 3'd3,
    OP_SUSP      = 3'd4,
    OP_SUSP_PROG = 3'd5
  } pes_op_e;

  // operation kinds during which the main toggle bit runs
  function automatic logic op_runs(input pes_op_e op);
    return (op == OP_PROG) || (op == OP_BERASE) ||
           (op == OP_CERASE) || (op == OP_SUSP_PROG);
  endfunction

  // place the five status flags at their bit positions; others zero
  function automatic logic [15:0] pack_status(input logic poll, input logic tog_a,
                                              input logic err, input logic started,
                                              input logic tog_b);
    logic [15:0] w;
    w    = 16'h0000;
    w[7] = poll;
    w[6] = tog_a;
    w[5] = err;
    w[3] = started;
    w[2] = tog_b;
    return w;
  endfunction

endpackage

// File: rtl/pes_toggle.sv
module pes_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else if (flip) q <= ~q;
  end
endmodule

// File: rtl/pes_fail_track.sv
module pes_fail_track
  import pes_pkg::*;
#(
  parameter int NUM_BLK = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pes_op_e            op,
  input  logic               prog_bit7,
  input  logic [NUM_BLK-1:0] erase_sel,
  input  logic               fail_evt,
  input  logic               clr_err,
  output logic               err_q,
  output logic [NUM_BLK-1:0] fail_mask,
  output logic               fail_prog,
  output logic               fail_b7
);
  logic [NUM_BLK-1:0] mask_next;
  logic               prog_kind;

  always_comb begin
    prog_kind = (op == OP_PROG) || (op == OP_SUSP_PROG);
    unique case (op)
      OP_CERASE: mask_next = '1;
      OP_BERASE: mask_next = erase_sel;
      default:   mask_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q     <= 1'b0;
      fail_mask <= '0;
      fail_prog <= 1'b0;
      fail_b7   <= 1'b0;
    end else if (fail_evt) begin
      err_q     <= 1'b1;
      fail_mask <= mask_next;
      fail_prog <= prog_kind;
      fail_b7   <= prog_bit7;
    end else if (clr_err) begin
      err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pes_word_mux.sv
module pes_word_mux
  import pes_pkg::*;
#(
  parameter int NUM_BLK = 5,
  parameter int BLK_W   = 3
) (
  input  pes_op_e            op,
  input  logic               prog_bit7,
  input  logic [NUM_BLK-1:0] erase_sel,
  input  logic [BLK_W-1:0]   rd_blk,
  input  logic               rd_stb,
  input  logic [15:0]        array_q,
  input  logic               win_open,
  input  logic               err_q,
  input  logic [NUM_BLK-1:0] fail_mask,
  input  logic               fail_prog,
  input  logic               fail_b7,
  input  logic               t6_q,
  input  logic               t2_q,
  output logic [15:0]        word,
  output logic               t6_flip,
  output logic               t2_flip,
  output logic               status_sel,
  output logic               blk_hit
);
  logic fail_hit;
  logic erase_hit;
  logic t2_run;
  logic t6_run;

  always_comb begin
    blk_hit  = 1'b0;
    fail_hit = 1'b0;
    for (int i = 0; i < NUM_BLK; i++) begin
      if (rd_blk == BLK_W'(i)) begin
        blk_hit  = erase_sel[i];
        fail_hit = fail_mask[i];
      end
    end
  end

  always_comb begin
    erase_hit  = (op == OP_CERASE) || blk_hit;
    t6_run     = op_runs(op);
    t2_run     = 1'b0;
    status_sel = 1'b1;
    word       = array_q;
    unique case (op)
      OP_PROG:
        word = pack_status(~prog_bit7, t6_q, err_q, 1'b0, 1'b1);
      OP_BERASE, OP_CERASE: begin
        t2_run = erase_hit;
        word   = pack_status(1'b0, t6_q, err_q, ~win_open, erase_hit ? t2_q : 1'b1);
      end
      OP_SUSP: begin
        t2_run     = blk_hit;
        status_sel = blk_hit;
        if (blk_hit) word = pack_status(1'b1, 1'b1, err_q, 1'b1, t2_q);
      end
      OP_SUSP_PROG: begin
        t2_run = blk_hit;
        word   = pack_status(~prog_bit7, t6_q, err_q, 1'b0, blk_hit ? t2_q : 1'b1);
      end
      default: begin
        status_sel = err_q;
        if (err_q) begin
          t6_run = 1'b1;
          t2_run = fail_hit;
          word   = pack_status(fail_prog ? ~fail_b7 : 1'b0, t6_q, 1'b1, 1'b1,
                               fail_hit ? t2_q : 1'b1);
        end
      end
    endcase
    t6_flip = rd_stb && t6_run;
    t2_flip = rd_stb && t2_run;
  end
endmodule

// File: rtl/pes_status_word.sv
module pes_status_word
  import pes_pkg::*;
#(
  parameter int NUM_BLK = 5,
  parameter int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         op_kind,
  input  logic               prog_bit7,
  input  logic [NUM_BLK-1:0] erase_sel,
  input  logic [BLK_W-1:0]   rd_blk,
  input  logic               rd_stb,
  input  logic [15:0]        array_q,
  input  logic               fail_evt,
  input  logic               clr_err,
  input  logic               win_open,
  output logic [15:0]        rd_data
);
  pes_op_e            op;
  logic               err_q;
  logic [NUM_BLK-1:0] fail_mask;
  logic               fail_prog;
  logic               fail_b7;
  logic               t6_q;
  logic               t2_q;
  logic               t6_flip;
  logic               t2_flip;
  logic               status_sel;
  logic               blk_hit;
  logic [15:0]        word;

  assign op = pes_op_e'(op_kind);

  pes_fail_track #(.NUM_BLK(NUM_BLK)) u_fail (
    .clk(clk), .rst_n(rst_n), .op(op), .prog_bit7(prog_bit7),
    .erase_sel(erase_sel), .fail_evt(fail_evt), .clr_err(clr_err),
    .err_q(err_q), .fail_mask(fail_mask), .fail_prog(fail_prog), .fail_b7(fail_b7)
  );

  pes_toggle u_tog6 (.clk(clk), .rst_n(rst_n), .flip(t6_flip), .q(t6_q));
  pes_toggle u_tog2 (.clk(clk), .rst_n(rst_n), .flip(t2_flip), .q(t2_q));

  pes_word_mux #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_mux (
    .op(op), .prog_bit7(prog_bit7), .erase_sel(erase_sel), .rd_blk(rd_blk),
    .rd_stb(rd_stb), .array_q(array_q), .win_open(win_open), .err_q(err_q),
    .fail_mask(fail_mask), .fail_prog(fail_prog), .fail_b7(fail_b7),
    .t6_q(t6_q), .t2_q(t2_q), .word(word), .t6_flip(t6_flip), .t2_flip(t2_flip),
    .status_sel(status_sel), .blk_hit(blk_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= 16'h0000;
    else if (rd_stb) rd_data <= word;
  end
endmodule

// File: rtl/pes_checker.sv
module pes_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  op_kind,
  input logic        prog_bit7,
  input logic        rd_stb,
  input logic        win_open,
  input logic        fail_evt,
  input logic        clr_err,
  input logic [15:0] rd_data,
  input logic        t6_q,
  input logic        t6_flip,
  input logic        err_q,
  input logic        blk_hit,
  input logic        status_sel
);
  a_r1_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && op_kind == 3'd1) |=>
      (rd_data[7] == !$past(prog_bit7)) && rd_data[2] && !rd_data[3]);

  a_r2_toggle_moves: assert property (@(posedge clk) disable iff (!rst_n)
    t6_flip |=> (t6_q != $past(t6_q)));

  a_r5_susp_block: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && op_kind == 3'd4 && blk_hit) |=> (rd_data[7:6] == 2'b11));

  a_r7_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> err_q);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_err) |=> err_q);

  a_r9_window: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && op_kind == 3'd2 && win_open) |=> !rd_data[3]);

  a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && status_sel) |=>
      (rd_data[15:8] == 8'h00) && !rd_data[4] && (rd_data[1:0] == 2'b00));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
endmodule

bind pes_status_word pes_checker u_chk (
  .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .prog_bit7(prog_bit7),
  .rd_stb(rd_stb), .win_open(win_open), .fail_evt(fail_evt), .clr_err(clr_err),
  .rd_data(rd_data), .t6_q(t6_q), .t6_flip(t6_flip), .err_q(err_q),
  .blk_hit(blk_hit), .status_sel(status_sel)
);

// File: tb/tb_pes_status_word.sv
`timescale 1ns/1ps
module tb_pes_status_word;
  localparam int NB = 5;
  localparam int BW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    op_kind = 3'd0;
  logic          prog_bit7 = 1'b0;
  logic [NB-1:0] erase_sel = '0;
  logic [BW-1:0] rd_blk = '0;
  logic          rd_stb = 1'b0;
  logic [15:0]   array_q = 16'h0000;
  logic          fail_evt = 1'b0;
  logic          clr_err = 1'b0;
  logic          win_open = 1'b0;
  logic [15:0]   rd_data;

  always #2 clk = ~clk;

  pes_status_word #(.NUM_BLK(NB), .BLK_W(BW)) dut (.*);

  int n_cmp = 0;
  int n_bad = 0;

  // bench-side model state
  logic          m_t6 = 0, m_t2 = 0, m_err = 0, m_fprog = 0, m_fb7 = 0;
  logic [NB-1:0] m_fmask = '0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic sel_of(int blk);
    return (blk < NB) ? erase_sel[blk] : 1'b0;
  endfunction

  function automatic logic failsel_of(int blk);
    return (blk < NB) ? m_fmask[blk] : 1'b0;
  endfunction

  // driver: computes expectation from the requirements, then strobes
  task automatic do_read(int blk, string tag);
    logic [15:0] w;
    logic chosen, chosen_f, f6, f2;
    rd_blk   = BW'(blk);
    chosen   = (op_kind == 3'd3) || sel_of(blk);
    chosen_f = failsel_of(blk);
    w = 16'h0000;
    f6 = 0; f2 = 0;
    case (op_kind)
      3'd1: begin w[7] = ~prog_bit7; w[6] = m_t6; w[5] = m_err; w[2] = 1; f6 = 1; end
      3'd2, 3'd3: begin
        w[6] = m_t6; w[5] = m_err; w[3] = ~win_open;
        w[2] = chosen ? m_t2 : 1'b1; f6 = 1; f2 = chosen;
      end
      3'd4: begin
        if (chosen) begin w[7] = 1; w[6] = 1; w[5] = m_err; w[3] = 1; w[2] = m_t2; f2 = 1; end
        else w = array_q;
      end
      3'd5: begin
        w[7] = ~prog_bit7; w[6] = m_t6; w[5] = m_err;
        w[2] = chosen ? m_t2 : 1'b1; f6 = 1; f2 = chosen;
      end
      default: begin
        if (m_err) begin
          w[7] = m_fprog ? ~m_fb7 : 1'b0; w[6] = m_t6; w[5] = 1; w[3] = 1;
          w[2] = chosen_f ? m_t2 : 1'b1; f6 = 1; f2 = chosen_f;
        end else w = array_q;
      end
    endcase
    if (f6) m_t6 = ~m_t6;
    if (f2) m_t2 = ~m_t2;
    exp_q.push_back(w);
    tag_q.push_back(tag);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic fail_pulse(logic also_clr);
    fail_evt = 1'b1;
    clr_err  = also_clr;
    m_err    = 1'b1;
    m_fprog  = (op_kind == 3'd1) || (op_kind == 3'd5);
    m_fb7    = prog_bit7;
    m_fmask  = (op_kind == 3'd3) ? '1 : (op_kind == 3'd2) ? erase_sel : '0;
    @(negedge clk);
    fail_evt = 1'b0;
    clr_err  = 1'b0;
  endtask

  task automatic clear_pulse();
    clr_err = 1'b1;
    m_err   = 1'b0;
    @(negedge clk);
    clr_err = 1'b0;
  endtask

  // monitor: pops one expectation per strobed edge
  initial begin
    forever begin
      logic seen;
      @(posedge clk);
      seen = rd_stb && rd_n;
      @(negedge clk);
      if (seen) begin
        if (exp_q.size() == 0) chk("R11 unexpected result", rd_data, 16'hxxxx);
        else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end
  wire rd_n = rst_n;

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset value", rd_data, 16'h0000);

    // program, data bit 7 = 1 then 0; back-to-back reads differ on bit 6
    op_kind = 3'd1; prog_bit7 = 1'b1;
    do_read(0, "R1 program poll b7=1");
    do_read(0, "R2 program toggle second read");
    prog_bit7 = 1'b0;
    do_read(4, "R1 program poll b7=0");

    // done: back to array data, equal reads
    op_kind = 3'd0; array_q = 16'h1234;
    do_read(0, "R10 idle pass-through");
    do_read(0, "R2 idle repeat equal");

    // block erase with window open then closed
    op_kind = 3'd2; erase_sel = 5'b00101; win_open = 1'b1;
    do_read(0, "R3 erase selected block");
    do_read(0, "R3 erase selected toggles");
    do_read(1, "R3 erase unselected block");
    win_open = 1'b0;
    do_read(2, "R9 erase started");

    // chip erase ignores mask
    op_kind = 3'd3; erase_sel = '0;
    do_read(1, "R4 chip erase block1");
    do_read(3, "R4 chip erase block3");

    // suspended erase
    op_kind = 3'd4; erase_sel = 5'b00100; array_q = 16'hA5C3;
    do_read(2, "R5 suspend selected");
    do_read(2, "R5 suspend selected again");
    do_read(0, "R5 suspend other block");
    do_read(6, "R5 suspend out-of-range block");

    // program inside suspend
    op_kind = 3'd5; prog_bit7 = 1'b1;
    do_read(2, "R6 suspend-program selected");
    do_read(3, "R6 suspend-program other");

    // erase failure, then idle with error held
    op_kind = 3'd2; erase_sel = 5'b01000; win_open = 1'b0;
    fail_pulse(1'b0);
    do_read(3, "R7 error bit during erase");
    op_kind = 3'd0;
    do_read(3, "R8 failed block read");
    do_read(3, "R8 failed block toggles");
    do_read(1, "R8 healthy block read");
    clear_pulse();
    do_read(1, "R7 cleared returns array");

    // program failure with simultaneous clear: set wins
    op_kind = 3'd1; prog_bit7 = 1'b0;
    fail_pulse(1'b1);
    op_kind = 3'd0;
    do_read(2, "R8 program failure idle word");
    clear_pulse();

    // hold without strobe
    @(negedge clk);
    held = rd_data;
    array_q = 16'h0F0F;
    @(negedge clk);
    @(negedge clk);
    chk("R11 held without strobe", rd_data, held);

    repeat (3) @(negedge clk);
    chk("R11 scoreboard drained", 16'(exp_q.size()), 16'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule